// File: doc/BRIEF.md
# External Memory Read Cycle Sequencer

This block drives the chip-select and read-strobe pins of one external memory area during read transfers. A request carries a byte address and a transfer size. On the cycle it accepts a request, the sequencer latches the area's configuration: the bus width code, the mode (plain static memory, static memory with byte control, or burst ROM), the read-strobe wait count, the gap between strobe release and select release, the read hold option and the burst pitch. It then runs one bus beat, or several when the access is wider than the bus. For each beat it presents an address, marks the cycle in which the pin data is captured, and packs the captured bytes into a result word.

In the static-memory modes every beat is a separate strobe. The hold option adds one cycle to the strobe after the capture point and takes one cycle out of the gap that follows. In burst-ROM mode the strobe stays low across all beats. From the third beat onward, a pitch count of idle cycles comes before each beat, and a nonzero pitch also makes every capture wait for the ready pin. The result is handed back with a one-cycle done pulse. An error flag comes with the pulse when the configuration was not legal.

Top module: `extmem_rd_seq`

## Requirements
- R1: Out of reset, cs_n and rd_n are 1, and sample, done, err and busy are 0.
- R2: The width code gives the bus bytes used per beat: 01 is 1 byte, 10 is 2 bytes and 11 is 4 bytes. The size code gives the access bytes: 00 is 1, 01 is 2, and 10 or 11 is 4. An access runs max(1, access/bus) beats. Beat k presents the address req_addr + k*bus bytes, and its data is taken from the low bus bytes of pin_data.
- R3: In the static modes with hold off, cs_n and rd_n fall in the cycle after acceptance. For each beat, rd_n stays low for WAIT+1 cycles and sample is high in the last of them. rd_n is then high, with cs_n still low, for GAP cycles, and the next beat (if any) starts in the cycle after that.
- R4: In the static modes with hold on, each beat keeps rd_n low for WAIT+2 cycles and sample is still high in cycle WAIT+1 of the beat. The gap after the beat shrinks to GAP-1 cycles, and to 0 cycles when GAP is 0.
- R5: In burst-ROM mode the hold input has no effect on timing.
- R6: In burst-ROM mode rd_n stays low from the first beat to the last. Beats 0 and 1 each take WAIT+1 cycles. Each later beat is preceded by PITCH cycles with no capture. After the last capture, cs_n stays low for GAP cycles with rd_n high.
- R7: In burst-ROM mode with a nonzero pitch, a capture takes place only in a cycle where rdy is 1, and the beat is extended until then. With pitch 0, and in the static modes, rdy is ignored.
- R8: done is high for exactly one cycle: the first cycle after the last cs_n-low cycle, with cs_n already high. In that cycle, rdata holds the access bytes in little-endian order (byte k from address req_addr+k), and the bytes above the access size are 0.
- R9: Width code 00 is handled as a 4-byte bus, and err is 1 during done.
- R10: In byte-control static mode, width code 01 is handled as a 2-byte bus and err is 1 during done. Codes 10 and 11 give no error.
- R11: A request is accepted only while busy is 0. busy stays high from the cycle after acceptance through the done cycle, and requests made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken while idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| cfg_width | input | 2 | Bus width code |
| cfg_rd_hold | input | 1 | Read hold option |
| cfg_burst | input | 1 | Burst-ROM mode select |
| cfg_bytectl | input | 1 | Byte-control static mode select (static only) |
| cfg_wait | input | WAIT_W | Extra strobe cycles before capture |
| cfg_gap | input | GAP_W | Strobe release to select release cycles |
| cfg_pitch | input | PITCH_W | Burst idle cycles per later beat; nonzero enables rdy |
| rdy | input | 1 | Ready from the memory |
| pin_data | input | 32 | Read data from the pins |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Address of the current beat |
| sample | output | 1 | pin_data is captured at the end of this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, valid with done |
| err | output | 1 | Illegal configuration flag, valid with done |
| busy | output | 1 | An access is in progress |

## Verification
The bench targets the hold option at GAP 0 and GAP 2. A design that shifts the capture instead of extending the strobe, or that lets the gap wrap below zero, would show a wrong capture cycle or a very long select. Burst runs of four beats check that the pitch is applied only from the third beat on, and that the hold option is dropped in that mode. A ready pin held low at the start of a burst must extend only the first beat when the pitch is nonzero, and must make no difference when the pitch is zero or the mode is static. Reserved and byte-control width codes, a 1-byte read on a 4-byte bus, and a request made in mid-access check that the flags, the zero upper bytes and the ignored request all come out right.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
    localparam int XRS_LANES = 4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_STRB  = 3'd1,
        S_HOLD  = 3'd2,
        S_GAP   = 3'd3,
        S_PITCH = 3'd4,
        S_FIN   = 3'd5
    } seq_state_e;

    localparam logic [1:0] WCODE_RSVD = 2'b00;
    localparam logic [1:0] WCODE_B8   = 2'b01;
    localparam logic [1:0] WCODE_B16  = 2'b10;
    localparam logic [1:0] WCODE_B32  = 2'b11;
endpackage

// File: rtl/xrs_width_dec.sv
module xrs_width_dec
    import xrs_pkg::*;
(
    input  logic [1:0] width_code,
    input  logic       bytectl,
    input  logic [1:0] size_code,
    output logic [1:0] bpb_log2,
    output logic [1:0] size_log2,
    output logic [1:0] last_beat,
    output logic       cfg_err
);
    logic [1:0] beats_log2;

    always_comb begin
        cfg_err  = 1'b0;
        case (width_code)
            WCODE_B8:  bpb_log2 = 2'd0;
            WCODE_B16: bpb_log2 = 2'd1;
            WCODE_B32: bpb_log2 = 2'd2;
            default: begin
                bpb_log2 = 2'd2;
                cfg_err  = 1'b1;
            end
        endcase
        // byte-control static memory needs at least a 16-bit bus
        if (bytectl && width_code == WCODE_B8) begin
            bpb_log2 = 2'd1;
            cfg_err  = 1'b1;
        end

        case (size_code)
            2'b00:   size_log2 = 2'd0;
            2'b01:   size_log2 = 2'd1;
            default: size_log2 = 2'd2;
        endcase

        beats_log2 = (size_log2 > bpb_log2) ? (size_log2 - bpb_log2) : 2'd0;
        case (beats_log2)
            2'd0:    last_beat = 2'd0;
            2'd1:    last_beat = 2'd1;
            default: last_beat = 2'd3;
        endcase
    end
endmodule

// File: rtl/xrs_byte_pack.sv
module xrs_byte_pack
    import xrs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   we,
    input  logic [1:0]             beat,
    input  logic [1:0]             bpb_log2,
    input  logic [1:0]             size_log2,
    input  logic [8*XRS_LANES-1:0] pin_data,
    output logic [8*XRS_LANES-1:0] data
);
    logic [3:0] off_w;

    assign off_w = {2'b00, beat} << bpb_log2;

    for (genvar i = 0; i < XRS_LANES; i++) begin : g_lane
        logic [3:0] rel;
        logic       hit;
        logic [7:0] lane_d;
        logic [7:0] lane_q;

        always_comb begin
            rel    = 4'(i) - off_w;
            hit    = we && (4'(i) >= off_w)
                        && (rel < (4'd1 << bpb_log2))
                        && (4'(i) < (4'd1 << size_log2));
            lane_d = lane_q;
            if (clear)
                lane_d = 8'h00;
            else if (hit)
                lane_d = pin_data[rel[1:0]*8 +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= 8'h00;
            else        lane_q <= lane_d;
        end

        assign data[i*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/extmem_rd_seq.sv
module extmem_rd_seq
    import xrs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WAIT_W  = 4,
    parameter int GAP_W   = 2,
    parameter int PITCH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [1:0]         cfg_width,
    input  logic               cfg_rd_hold,
    input  logic               cfg_burst,
    input  logic               cfg_bytectl,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [GAP_W-1:0]   cfg_gap,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic               rdy,
    input  logic [31:0]        pin_data,
    output logic               cs_n,
    output logic               rd_n,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               sample,
    output logic               done,
    output logic [31:0]        rdata,
    output logic               err,
    output logic               busy
);
    localparam int CW1   = (WAIT_W > GAP_W) ? WAIT_W : GAP_W;
    localparam int CNT_W = (CW1 > PITCH_W) ? CW1 : PITCH_W;

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         beat;
        logic [1:0]         last_beat;
        logic [1:0]         bpb_log2;
        logic [1:0]         size_log2;
        logic [ADDR_W-1:0]  addr;
        logic               hold;
        logic               burst;
        logic [WAIT_W-1:0]  wait_n;
        logic [GAP_W-1:0]   gap;
        logic [PITCH_W-1:0] pitch;
        logic               err;
    } seq_t;

    seq_t r_d, r_q;

    logic [1:0]       dec_bpb, dec_size, dec_last;
    logic             dec_err;
    logic             accept;
    logic             ready_gate;
    logic             sample_c;
    logic             more;
    logic [GAP_W-1:0] gap_eff;
    logic [ADDR_W-1:0] step;

    xrs_width_dec u_wdec (
        .width_code (cfg_width),
        .bytectl    (cfg_bytectl & ~cfg_burst),
        .size_code  (req_size),
        .bpb_log2   (dec_bpb),
        .size_log2  (dec_size),
        .last_beat  (dec_last),
        .cfg_err    (dec_err)
    );

    assign accept     = (r_q.st == S_IDLE) && req_valid;
    assign ready_gate = r_q.burst && (r_q.pitch != '0);
    assign sample_c   = (r_q.st == S_STRB) && (r_q.cnt == '0) && (!ready_gate || rdy);
    assign more       = (r_q.beat != r_q.last_beat);
    assign step       = ADDR_W'(1) << r_q.bpb_log2;
    // hold is stored only for static modes; it trades one gap cycle
    assign gap_eff    = !r_q.hold ? r_q.gap :
                        ((r_q.gap != '0) ? (r_q.gap - GAP_W'(1)) : '0);

    always_comb begin
        logic tail;
        logic gap_end;
        r_d     = r_q;
        tail    = 1'b0;
        gap_end = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st        = S_STRB;
                    r_d.cnt       = CNT_W'(cfg_wait);
                    r_d.beat      = 2'd0;
                    r_d.last_beat = dec_last;
                    r_d.bpb_log2  = dec_bpb;
                    r_d.size_log2 = dec_size;
                    r_d.addr      = req_addr;
                    r_d.hold      = cfg_rd_hold & ~cfg_burst;
                    r_d.burst     = cfg_burst;
                    r_d.wait_n    = cfg_wait;
                    r_d.gap       = cfg_gap;
                    r_d.pitch     = cfg_pitch;
                    r_d.err       = dec_err;
                end
            end
            S_STRB: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (sample_c) begin
                    if (r_q.burst && more) begin
                        r_d.beat = r_q.beat + 2'd1;
                        r_d.addr = r_q.addr + step;
                        if (r_q.beat != 2'd0 && r_q.pitch != '0) begin
                            r_d.st  = S_PITCH;
                            r_d.cnt = CNT_W'(r_q.pitch) - CNT_W'(1);
                        end else begin
                            r_d.st  = S_STRB;
                            r_d.cnt = CNT_W'(r_q.wait_n);
                        end
                    end else if (r_q.hold) begin
                        r_d.st = S_HOLD;
                    end else begin
                        tail = 1'b1;
                    end
                end
            end
            S_HOLD: tail = 1'b1;
            S_GAP: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - CNT_W'(1);
                else               gap_end = 1'b1;
            end
            S_PITCH: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.st  = S_STRB;
                    r_d.cnt = CNT_W'(r_q.wait_n);
                end
            end
            S_FIN:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase

        if (tail) begin
            if (gap_eff != '0) begin
                r_d.st  = S_GAP;
                r_d.cnt = CNT_W'(gap_eff) - CNT_W'(1);
            end else begin
                gap_end = 1'b1;
            end
        end

        if (gap_end) begin
            if (more) begin
                r_d.st   = S_STRB;
                r_d.cnt  = CNT_W'(r_q.wait_n);
                r_d.beat = r_q.beat + 2'd1;
                r_d.addr = r_q.addr + step;
            end else begin
                r_d.st = S_FIN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= S_IDLE;
            r_q.pitch     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    xrs_byte_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .we        (sample_c),
        .beat      (r_q.beat),
        .bpb_log2  (r_q.bpb_log2),
        .size_log2 (r_q.size_log2),
        .pin_data  (pin_data),
        .data      (rdata)
    );

    assign cs_n     = (r_q.st == S_IDLE) || (r_q.st == S_FIN);
    assign rd_n     = !((r_q.st == S_STRB) || (r_q.st == S_HOLD) || (r_q.st == S_PITCH));
    assign bus_addr = r_q.addr;
    assign sample   = sample_c;
    assign done     = (r_q.st == S_FIN);
    assign err      = done && r_q.err;
    assign busy     = (r_q.st != S_IDLE);
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic rdy,
    input logic cs_n,
    input logic rd_n,
    input logic sample,
    input logic done,
    input logic err,
    input logic busy,
    input logic ready_gate
);
    a_r3_rd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    a_r3_sample_under_rd: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !rd_n);

    a_r7_ready_gates_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && ready_gate) |-> rdy);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    a_r9_err_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && !cs_n));

    a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind extmem_rd_seq xrs_checker u_xrs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rdy        (rdy),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .sample     (sample),
    .done       (done),
    .err        (err),
    .busy       (busy),
    .ready_gate (ready_gate)
);

// File: tb/tb_extmem_rd_seq.sv
module tb_extmem_rd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  cfg_width = 2'b11;
    logic        cfg_rd_hold = 1'b0;
    logic        cfg_burst = 1'b0;
    logic        cfg_bytectl = 1'b0;
    logic [3:0]  cfg_wait = '0;
    logic [1:0]  cfg_gap = '0;
    logic [2:0]  cfg_pitch = '0;
    logic        rdy = 1'b1;
    logic [31:0] pin_data;
    logic        cs_n, rd_n, sample, done, err, busy;
    logic [31:0] bus_addr, rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5ns clk = ~clk;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign pin_data = {pat(bus_addr + 32'd3), pat(bus_addr + 32'd2),
                       pat(bus_addr + 32'd1), pat(bus_addr)};

    extmem_rd_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .cfg_width(cfg_width), .cfg_rd_hold(cfg_rd_hold),
        .cfg_burst(cfg_burst), .cfg_bytectl(cfg_bytectl), .cfg_wait(cfg_wait),
        .cfg_gap(cfg_gap), .cfg_pitch(cfg_pitch), .rdy(rdy), .pin_data(pin_data),
        .cs_n(cs_n), .rd_n(rd_n), .bus_addr(bus_addr), .sample(sample),
        .done(done), .rdata(rdata), .err(err), .busy(busy)
    );

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Runs one read and compares its timing, addresses and data with values
    // derived from the requirements.
    task automatic do_read(input string tag, input logic [31:0] addr,
                           input logic [1:0] size, input logic [1:0] width,
                           input bit hold, input bit burst, input bit bctl,
                           input int w, input int g, input int p,
                           input int rdy_low, input bit inject);
        int bpb_l, sz_l, beats, ge, per, exp_rd, exp_cs, exp_iv, stall, exp_first;
        bit exp_err;
        logic [31:0] exp_data;
        int cs_low, rd_low, n_samp, first_samp, iv, addr_bad, n_done, done_cyc;
        logic prev_rd;
        logic [31:0] got_data;
        logic got_err, cs_at_done;

        // expectations: R2, R9, R10
        bpb_l = (width == 2'b01) ? 0 : (width == 2'b10) ? 1 : 2;
        exp_err = (width == 2'b00);
        if (bctl && !burst && width == 2'b01) begin
            bpb_l = 1;
            exp_err = 1'b1;
        end
        sz_l  = (size == 2'b00) ? 0 : (size == 2'b01) ? 1 : 2;
        beats = (sz_l > bpb_l) ? (1 << (sz_l - bpb_l)) : 1;
        stall = (burst && p != 0 && rdy_low > w) ? (rdy_low - w) : 0;
        exp_first = w + 1 + stall;
        if (!burst) begin
            ge  = hold ? ((g == 0) ? 0 : g - 1) : g;   // R4
            per = w + 1 + (hold ? 1 : 0);
            exp_rd = beats * per;
            exp_cs = beats * (per + ge);
            exp_iv = (ge > 0) ? beats : 1;
        end else begin
            exp_rd = beats * (w + 1) + ((beats > 2) ? (beats - 2) * p : 0) + stall;  // R6
            exp_cs = exp_rd + g;
            exp_iv = 1;
        end
        exp_data = '0;
        for (int k = 0; k < (1 << sz_l); k++)
            exp_data[k*8 +: 8] = pat(addr + 32'(k));

        cfg_width = width; cfg_rd_hold = hold; cfg_burst = burst; cfg_bytectl = bctl;
        cfg_wait = 4'(w); cfg_gap = 2'(g); cfg_pitch = 3'(p);
        req_addr = addr; req_size = size; req_valid = 1'b1;
        cs_low = 0; rd_low = 0; n_samp = 0; first_samp = 0; iv = 0; addr_bad = 0;
        n_done = 0; done_cyc = 0; prev_rd = 1'b1; got_data = '0; got_err = 1'b0;
        cs_at_done = 1'b0;
        tick();
        req_valid = 1'b0;
        for (int c = 1; c <= 300 && n_done == 0; c++) begin
            if (c > 1) tick();
            rdy = (c > rdy_low);
            if (inject && c == 2) begin
                req_valid = 1'b1;
                req_addr  = addr + 32'h40;
            end
            if (inject && c == 3) req_valid = 1'b0;
            #1ns;
            if (!cs_n) cs_low++;
            if (!rd_n) rd_low++;
            if (!rd_n && prev_rd) iv++;
            prev_rd = rd_n;
            if (sample) begin
                if (n_samp == 0) first_samp = c;
                if (bus_addr != addr + 32'(n_samp << bpb_l)) addr_bad++;
                n_samp++;
            end
            if (done) begin
                n_done++;
                done_cyc = c;
                got_data = rdata;
                got_err = err;
                cs_at_done = cs_n;
            end
        end
        req_valid = 1'b0;
        chk(n_done == 1, tag, "done seen (R8)", 32'(n_done), 32'd1);
        chk(cs_low == exp_cs, tag, "cs low cycles (R3)", 32'(cs_low), 32'(exp_cs));
        chk(rd_low == exp_rd, tag, "rd low cycles (R3)", 32'(rd_low), 32'(exp_rd));
        chk(iv == exp_iv, tag, "rd low intervals (R6)", 32'(iv), 32'(exp_iv));
        chk(n_samp == beats, tag, "beat count (R2)", 32'(n_samp), 32'(beats));
        chk(first_samp == exp_first, tag, "first capture cycle (R7)",
            32'(first_samp), 32'(exp_first));
        chk(addr_bad == 0, tag, "beat addresses (R2)", 32'(addr_bad), 32'd0);
        chk(done_cyc == exp_cs + 1, tag, "done cycle (R8)", 32'(done_cyc), 32'(exp_cs + 1));
        chk(cs_at_done == 1'b1, tag, "cs_n at done (R8)", 32'(cs_at_done), 32'd1);
        chk(got_data == exp_data, tag, "assembled data (R8)", got_data, exp_data);
        chk(got_err == exp_err, tag, "error flag (R9/R10)", 32'(got_err), 32'(exp_err));
        tick();
        chk(done == 1'b0, tag, "done is one cycle (R8)", 32'(done), 32'd0);
        if (inject) begin
            for (int j = 0; j < 3; j++) begin
                chk(cs_n == 1'b1 && busy == 1'b0, "R11", "no access from ignored request",
                    {30'd0, busy, cs_n}, 32'd1);
                tick();
            end
        end
        rdy = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1", "cs_n after reset", 32'(cs_n), 32'd1);
        chk(rd_n == 1'b1, "R1", "rd_n after reset", 32'(rd_n), 32'd1);
        chk({sample, done, err, busy} == 4'b0, "R1", "flags after reset",
            32'({sample, done, err, busy}), 32'd0);
    endtask

    task automatic t_static_plain();
        do_read("R3", 32'h1000, 2'b10, 2'b11, 0, 0, 0, 2, 2, 0, 0, 0);
        do_read("R2", 32'h2001, 2'b10, 2'b01, 0, 0, 0, 0, 1, 0, 0, 0);
        do_read("R2", 32'h2202, 2'b01, 2'b01, 0, 0, 0, 1, 3, 0, 0, 0);
    endtask

    task automatic t_static_hold();
        do_read("R4", 32'h3000, 2'b10, 2'b10, 1, 0, 0, 1, 2, 0, 0, 0);
        do_read("R4", 32'h3105, 2'b00, 2'b11, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_burst();
        do_read("R6", 32'h4000, 2'b10, 2'b01, 0, 1, 0, 1, 1, 3, 0, 0);
        do_read("R5", 32'h4100, 2'b10, 2'b01, 1, 1, 0, 1, 1, 3, 0, 0);
        do_read("R6", 32'h4200, 2'b10, 2'b10, 0, 1, 0, 0, 2, 7, 0, 0);
    endtask

    task automatic t_ready();
        do_read("R7", 32'h5000, 2'b10, 2'b01, 0, 1, 0, 1, 1, 2, 4, 0);
        do_read("R7", 32'h5100, 2'b10, 2'b01, 0, 1, 0, 1, 1, 0, 6, 0);
        do_read("R7", 32'h5200, 2'b10, 2'b10, 0, 0, 0, 1, 1, 5, 1000, 0);
    endtask

    task automatic t_codes();
        do_read("R9", 32'h6000, 2'b10, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0);
        do_read("R10", 32'h6100, 2'b10, 2'b01, 0, 0, 1, 0, 1, 0, 0, 0);
        do_read("R10", 32'h6200, 2'b10, 2'b10, 0, 0, 1, 0, 1, 0, 0, 0);
        do_read("R8", 32'h6303, 2'b00, 2'b11, 0, 0, 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_busy_ignore();
        do_read("R11", 32'h7000, 2'b10, 2'b01, 0, 0, 0, 1, 1, 0, 0, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_static_plain();
        t_static_hold();
        t_burst();
        t_ready();
        t_codes();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500us;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-R11 stalled: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule